// File: doc/BRIEF.md
# Lower-Part OR Approximate Adder

This block adds two unsigned operands of `WIDTH` bits and trades accuracy in the least significant bits for a shorter carry chain. The operands are cut at a boundary set by `APPROX_BITS`. Below the boundary each result bit is the OR of the two operand bits at that position, and there is no carry logic. At and above the boundary a ripple-carry chain adds the upper fields exactly. The carry out of that chain becomes the extra top bit of the `WIDTH+1`-bit result.

The block is purely combinational: it has no clock, no reset and no handshake. It suits datapaths such as filter accumulations, where a small error in the low bits is acceptable and a shorter adder saves area and power. With `APPROX_BITS = 0` it is an exact adder. With `APPROX_BITS = WIDTH` it reduces to a plain OR.

Top module: `lor_adder`

## Requirements
- R1: For each bit position p < APPROX_BITS, sum_o[p] equals a_i[p] | b_i[p].
- R2: No carry passes from the OR field into the upper field. For example, with WIDTH=16 and APPROX_BITS=6, adding 0x003F and 0x0001 gives 0x0003F, not 0x00040.
- R3: sum_o[WIDTH-1:APPROX_BITS] equals the low WIDTH-APPROX_BITS bits of the exact sum a_i[WIDTH-1:APPROX_BITS] + b_i[WIDTH-1:APPROX_BITS].
- R4: sum_o[WIDTH] is the carry out of the upper-field addition. It is 0 when APPROX_BITS equals WIDTH.
- R5: With APPROX_BITS = 0, sum_o equals the exact sum a_i + b_i over WIDTH+1 bits.
- R6: With APPROX_BITS = WIDTH, sum_o equals {1'b0, a_i | b_i}.
- R7: The output follows the inputs with no clock edge involved; new operands show up at sum_o within the same time step.
- R8: The carry into the lowest bit of the upper chain is zero. When both operands have all-zero low fields and b_i is zero, sum_o equals a_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| sum_o | output | WIDTH+1 | Approximate sum; the top bit is the upper-field carry out |

## Verification
The bench goes after the points where approximation and exact arithmetic meet:
- Low fields that would carry, such as 0x3F plus 0x01. A design that leaked that carry upward would give the exact sum instead of 0x0003F.
- All-ones and alternating patterns. These expose a chain that drops its top carry or that starts with a carry-in of one, which would add one to every upper field.
- The two extreme splits, built as separate instances. They catch generate branches that mis-size a field or leave the top bit floating when no upper field exists.

// File: rtl/lor_pkg.sv
package lor_pkg;
  localparam int unsigned LOR_DEF_WIDTH  = 16;
  localparam int unsigned LOR_DEF_APPROX = 6;

  // Width of the exact upper field for a given split.
  function automatic int unsigned lor_hi_width(input int unsigned w, input int unsigned l);
    return w - l;
  endfunction
endpackage

// File: rtl/lor_or_field.sv
module lor_or_field #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  for (genvar p = 0; p < W; p++) begin : g_bit
    assign y_o[p] = a_i[p] | b_i[p];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R1
      or_cover_chk: assert (((y_o & a_i) == a_i) && ((y_o & b_i) == b_i));
      // R1
      or_no_extra_chk: assert ((y_o & ~a_i & ~b_i) == '0);
    end
  end
endmodule

// File: rtl/lor_fa.sv
module lor_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half;
  assign half = a_i ^ b_i;
  assign s_o  = half ^ c_i;
  assign c_o  = (a_i & b_i) | (half & c_i);
endmodule

// File: rtl/lor_ripple.sv
module lor_ripple #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_cell
    lor_fa u_fa (
      .a_i (a_i[k]),
      .b_i (b_i[k]),
      .c_i (carry[k]),
      .s_o (s_o[k]),
      .c_o (carry[k+1])
    );
  end

  assign co_o = carry[W];

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R8
      ripple_cin_zero_chk: assert (({co_o, s_o} - {1'b0, a_i}) == {1'b0, b_i});
    end
  end
endmodule

// File: rtl/lor_adder.sv
module lor_adder
  import lor_pkg::*;
#(
  parameter int unsigned WIDTH       = LOR_DEF_WIDTH,
  parameter int unsigned APPROX_BITS = LOR_DEF_APPROX
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   sum_o
);
  localparam int unsigned HI_W = lor_hi_width(WIDTH, APPROX_BITS);

  if (APPROX_BITS > 0) begin : g_lo
    logic [APPROX_BITS-1:0] lo_y;
    lor_or_field #(.W(APPROX_BITS)) u_or (
      .a_i (a_i[APPROX_BITS-1:0]),
      .b_i (b_i[APPROX_BITS-1:0]),
      .y_o (lo_y)
    );
    assign sum_o[APPROX_BITS-1:0] = lo_y;
  end

  if (HI_W > 0) begin : g_hi
    logic [HI_W-1:0] hi_s;
    logic            hi_c;
    lor_ripple #(.W(HI_W)) u_rc (
      .a_i  (a_i[WIDTH-1:APPROX_BITS]),
      .b_i  (b_i[WIDTH-1:APPROX_BITS]),
      .s_o  (hi_s),
      .co_o (hi_c)
    );
    assign sum_o[WIDTH-1:APPROX_BITS] = hi_s;
    assign sum_o[WIDTH]               = hi_c;

    always_comb begin
      if (!$isunknown({a_i, b_i})) begin
        // R3
        hi_exact_chk: assert ((sum_o[WIDTH:APPROX_BITS] - {1'b0, a_i[WIDTH-1:APPROX_BITS]})
                              == {1'b0, b_i[WIDTH-1:APPROX_BITS]});
      end
    end
  end else begin : g_no_hi
    assign sum_o[WIDTH] = 1'b0;

    always_comb begin
      // R4
      no_hi_msb_chk: assert (sum_o[WIDTH] !== 1'b1);
    end
  end
endmodule

// File: tb/lor_adder_tb.sv
module lor_adder_tb;
  localparam int unsigned N  = 16;
  localparam int unsigned L  = 6;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned NVEC = 7;

  // {a, b, expected} for N=16, L=6
  localparam logic [48:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 17'h00000},
    {16'hFFFF, 16'hFFFF, 17'h1FFBF},
    {16'hAAAA, 16'h5555, 17'h0FFFF},
    {16'h003F, 16'h0001, 17'h0003F},
    {16'h0040, 16'h0040, 17'h00080},
    {16'hFFC0, 16'h0040, 17'h10000},
    {16'h1234, 16'h0F0F, 17'h0213F}
  };

  logic clk = 1'b0;
  logic [N-1:0] a, b;
  logic [N:0]   s_mid, s_exact, s_or;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lor_adder #(.WIDTH(N), .APPROX_BITS(L)) u_dut       (.a_i(a), .b_i(b), .sum_o(s_mid));
  lor_adder #(.WIDTH(N), .APPROX_BITS(0)) u_dut_exact (.a_i(a), .b_i(b), .sum_o(s_exact));
  lor_adder #(.WIDTH(N), .APPROX_BITS(N)) u_dut_or    (.a_i(a), .b_i(b), .sum_o(s_or));

  function automatic logic [N:0] ref_model(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [N:0] m, hi;
    m  = (17'd1 << L) - 17'd1;
    hi = ({1'b0, x} >> L) + ({1'b0, y} >> L);
    return (({1'b0, x} | {1'b0, y}) & m) | (hi << L);
  endfunction

  task automatic check(input string req, input logic [N:0] got, input logic [N:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h got=%h expected=%h", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
    a = x;
    b = y;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a = '0;
    b = '0;
    #1;
    // R7: the first value settles with no clock edge
    check("R7", s_mid, '0);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][48:33], VEC[i][32:17]);
      check("R1/R2/R3/R4 table", s_mid, VEC[i][16:0]);
    end

    // R2: a low-field carry would give 0x40 if it leaked upward
    apply(16'h003F, 16'h0001);
    check("R2", s_mid, 17'h0003F);

    // R4: the top carry of the upper field reaches the MSB
    apply(16'h8000, 16'h8000);
    check("R4", s_mid, 17'h10000);

    // R8: zero carry-in into the upper chain
    apply(16'h5A40, 16'h0000);
    check("R8", s_mid, 17'h05A40);

    // R7: a change in the same time step, no clock wait
    a = 16'h0001;
    b = 16'h0002;
    #1;
    check("R7", s_mid, 17'h00003);

    // R5 R6: extreme splits on corner patterns
    apply(16'hFFFF, 16'hFFFF);
    check("R5", s_exact, 17'h1FFFE);
    check("R6", s_or, 17'h0FFFF);
    apply(16'hAAAA, 16'h5556);
    check("R5", s_exact, 17'h10000);
    check("R6", s_or, 17'h0FFFE);

    // R1 R3 R5 R6: random sweep
    for (int i = 0; i < 300; i++) begin
      apply(16'($urandom), 16'($urandom));
      check("R1/R3 random", s_mid, ref_model(a, b));
      check("R5 random", s_exact, {1'b0, a} + {1'b0, b});
      check("R6 random", s_or, {1'b0, a | b});
    end

    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule